// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Register Interface

This block sits between a host and the registers of a time-of-day clock. The host reaches it through an 8-bit bus that carries both address and data. A mode input picks one of two strobe schemes. In the enable-strobe scheme, one strobe frames the data phase and a direction line says whether the access is a read or a write. In the split-strobe scheme, there is a separate active-low read enable and a separate active-low write strobe. In both schemes, the address is taken from the bus when the address strobe falls. An extended-select line must be low for the access to reach this map.

All strobes are asynchronous to the block. Each one passes through a two-stage sampler running on the system clock, and edges are detected on the sampled copies.

The 256-byte map has three parts:
- The clock and calendar bytes, and the four control registers, live in the counting core. The block forwards them through a narrow register port that carries an address, a write pulse, data and a per-bit write mask.
- 242 general storage bytes are held inside the block.

The block also enforces the access rules of the control registers, pulses an acknowledge toward the flag logic after the flag register is read, clears all storage on a long-held wipe input, and blocks time and storage writes while the power-fail lock is raised.

Top module: `mbus_regif`

## Requirements
- R1: In enable-strobe mode (`strobe_mode`=1), a read with `dir_wr`=1, `sel_n`=0 and `data_stb` high drives `bus_out` with the addressed byte and raises `bus_oe`. `bus_oe` returns to 0 after `data_stb` falls.
- R2: In enable-strobe mode, the falling edge of `data_stb` with `dir_wr`=0 writes the value on `bus_in` to the addressed byte.
- R3: In split-strobe mode (`strobe_mode`=0), `data_stb` low is the read enable, and the rising edge of `dir_wr` captures write data.
- R4: With `sel_n` high during the data phase, a read leaves `bus_oe` at 0 and a write changes nothing.
- R5: When `ext_sel` was high at the address strobe fall, the access reaches nothing: no write takes effect and `bus_oe` stays 0.
- R6: Offsets 00h–0Dh go out on the core port, with `core_addr` equal to the low four offset bits and a one-cycle `core_wr`. Offsets 0Eh–FFh map to internal storage byte (offset − 0Eh).
- R7: A write to 0Ah (control A) carries `core_wmask`=7Fh, so bit 7 is never written. All other forwarded writes carry FFh.
- R8: A write to 0Ch (flag register) is forwarded only while `osc_field`=3'b011. Otherwise it is dropped.
- R9: 0Dh (validity register) is never written. A read of it returns core bit 7 with bits 6:0 forced to 0.
- R10: After a read of 0Ch ends, `evt_ack` pulses for exactly one cycle. Reads of other offsets give no pulse.
- R11: Holding `wipe_n` low for `WIPE_HOLD` sampled cycles sets all 242 storage bytes to FFh and issues no core write. A shorter low pulse changes nothing.
- R12: While `pwr_lock`=1, writes to 00h–09h and to storage are dropped. Writes to 0Ah–0Dh still follow R7–R9.
- R13: While `rst_n`=0, `bus_oe`, `core_wr` and `evt_ack` are 0, and bus activity changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all strobes |
| rst_n | input | 1 | Synchronous active-low reset; block ignores the bus while low |
| strobe_mode | input | 1 | 1 = enable strobe plus direction, 0 = split read/write strobes |
| addr_stb | input | 1 | Address strobe; falling edge captures the address |
| data_stb | input | 1 | Data strobe (mode 1) or active-low read enable (mode 0) |
| dir_wr | input | 1 | Direction, high = read (mode 1) or active-low write strobe (mode 0) |
| sel_n | input | 1 | Active-low select, qualifies the data phase |
| ext_sel | input | 1 | Extended-space select; must be low to reach this map |
| bus_in | input | 8 | Multiplexed address/data input |
| bus_out | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | Bus drive enable; 0 means high impedance |
| wipe_n | input | 1 | Active-low storage wipe request |
| pwr_lock | input | 1 | Power-fail write lock |
| osc_field | input | 3 | Oscillator control field of control A, from the core |
| core_addr | output | 4 | Register index toward the counting core |
| core_wr | output | 1 | One-cycle write pulse toward the core |
| core_wdata | output | 8 | Write data toward the core |
| core_wmask | output | 8 | Writable-bit mask for the core write |
| core_rdata | input | 8 | Core read data for `core_addr` |
| evt_ack | output | 1 | One-cycle pulse after the flag register is read |

## Verification
The assertions rely on certain properties of the bus stimulus:
- The latched address stays constant from a write's strobe edge until the forwarded `core_wr` appears.
- `osc_field`, `pwr_lock` and `sel_n` are stable for the few cycles that the sampler needs to report an edge.
- No address strobe falls while a data phase is still open.

The stimulus keeps within these assumptions by construction. Every strobe level is held for six clock cycles, and the address, data and select lines stay fixed around each edge. Mode is switched only when the bus is idle, with `data_stb` first moved to the idle level of the new mode, so no false edge is ever seen.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam logic [7:0] OFS_CAL_LAST   = 8'h09;
  localparam logic [7:0] OFS_CTL_A      = 8'h0A;
  localparam logic [7:0] OFS_CTL_C      = 8'h0C;
  localparam logic [7:0] OFS_CTL_D      = 8'h0D;
  localparam logic [7:0] OFS_STORE_BASE = 8'h0E;
  localparam logic [2:0] OSC_C_WRITABLE = 3'b011;

  typedef enum logic [1:0] {AREA_CAL, AREA_CTL, AREA_STORE} area_e;

  function automatic area_e area_of(input logic [7:0] ofs);
    if (ofs <= OFS_CAL_LAST) return AREA_CAL;
    else if (ofs < OFS_STORE_BASE) return AREA_CTL;
    else return AREA_STORE;
  endfunction

  // bits a host write may change
  function automatic logic [7:0] write_mask(input logic [7:0] ofs);
    return (ofs == OFS_CTL_A) ? 8'h7F : 8'hFF;
  endfunction

  function automatic logic write_ok(input logic [7:0] ofs, input logic [2:0] osc,
                                    input logic lock);
    case (area_of(ofs))
      AREA_CAL:   return !lock;
      AREA_STORE: return !lock;
      default: begin
        if (ofs == OFS_CTL_D) return 1'b0;
        if (ofs == OFS_CTL_C) return osc == OSC_C_WRITABLE;
        return 1'b1;
      end
    endcase
  endfunction

  function automatic logic [7:0] read_view(input logic [7:0] ofs, input logic [7:0] raw);
    return (ofs == OFS_CTL_D) ? {raw[7], 7'd0} : raw;
  endfunction

endpackage

// File: rtl/mbus_strobe_sync.sv
module mbus_strobe_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [STAGES:0][N-1:0] chain;
  logic [N-1:0]           prev;

  assign chain[0] = raw;

  // during reset every stage follows the pin, so release makes no edge
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s+1] <= raw;
      else        chain[s+1] <= chain[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= raw;
    else        prev <= chain[STAGES];
  end

  assign lvl  = chain[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/mbus_wipe_timer.sv
module mbus_wipe_timer #(
  parameter int unsigned HOLD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe_lvl,
  output logic fire
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (wipe_lvl) cnt <= '0;
      else if (cnt != CNT_W'(HOLD)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(HOLD - 1)) fire <= 1'b1;
      end
    end
  end

  a_r11_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/mbus_store.sv
module mbus_store #(
  parameter int unsigned DEPTH = 242,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < DEPTH; b++) begin
      if (wipe) mem[b] <= 8'hFF;
      else if (we && widx == IDX_W'(b)) mem[b] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  a_r11_wipe_all: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (mem[0] == 8'hFF) && (mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIPE_HOLD   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_mode,
  input  logic       addr_stb,
  input  logic       data_stb,
  input  logic       dir_wr,
  input  logic       sel_n,
  input  logic       ext_sel,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  input  logic       wipe_n,
  input  logic       pwr_lock,
  input  logic [2:0] osc_field,
  output logic [3:0] core_addr,
  output logic       core_wr,
  output logic [7:0] core_wdata,
  output logic [7:0] core_wmask,
  input  logic [7:0] core_rdata,
  output logic       evt_ack
);
  localparam int unsigned STORE_DEPTH = 256 - int'(OFS_STORE_BASE);
  localparam int unsigned N_SYNC      = 4;

  logic [N_SYNC-1:0] s_lvl, s_rise, s_fall;
  logic [7:0] addr_q, store_rdata, rd_byte;
  logic       ext_q, sel_ok, rd_phase, wr_evt, wr_allowed, store_we, wipe_fire;
  logic       c_rd_q;
  area_e      area;

  mbus_strobe_sync #(.N(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({wipe_n, dir_wr, data_stb, addr_stb}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  mbus_wipe_timer #(.HOLD(WIPE_HOLD)) u_wipe (
    .clk(clk), .rst_n(rst_n), .wipe_lvl(s_lvl[3]), .fire(wipe_fire)
  );

  // address phase: capture on sampled address strobe fall, select ignored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ext_q  <= 1'b1;
    end else if (s_fall[0]) begin
      addr_q <= bus_in;
      ext_q  <= ext_sel;
    end
  end

  assign area     = area_of(addr_q);
  assign sel_ok   = !ext_q && !sel_n;
  assign rd_phase = sel_ok && (strobe_mode ? (s_lvl[1] && s_lvl[2]) : !s_lvl[1]);
  assign wr_evt   = sel_ok && (strobe_mode ? (s_fall[1] && !s_lvl[2]) : s_rise[2]);
  assign wr_allowed = write_ok(addr_q, osc_field, pwr_lock);
  assign store_we = wr_evt && wr_allowed && (area == AREA_STORE);

  mbus_store #(.DEPTH(STORE_DEPTH), .IDX_W(8)) u_store (
    .clk(clk), .rst_n(rst_n), .wipe(wipe_fire),
    .we(store_we), .widx(addr_q - OFS_STORE_BASE), .wdata(bus_in),
    .ridx(addr_q - OFS_STORE_BASE), .rdata(store_rdata)
  );

  assign core_addr = addr_q[3:0];
  assign rd_byte   = (area == AREA_STORE) ? store_rdata : read_view(addr_q, core_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_wr    <= 1'b0;
      core_wdata <= '0;
      core_wmask <= '0;
      bus_oe     <= 1'b0;
      bus_out    <= '0;
      c_rd_q     <= 1'b0;
      evt_ack    <= 1'b0;
    end else begin
      core_wr <= wr_evt && wr_allowed && (area != AREA_STORE);
      if (wr_evt) begin
        core_wdata <= bus_in;
        core_wmask <= write_mask(addr_q);
      end
      bus_oe  <= rd_phase;
      bus_out <= rd_byte;
      c_rd_q  <= rd_phase && (addr_q == OFS_CTL_C);
      evt_ack <= c_rd_q && !(rd_phase && (addr_q == OFS_CTL_C));
    end
  end

  // R1: in enable-strobe mode the bus is only driven for a read direction
  a_r1_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && strobe_mode && $past(strobe_mode)) |-> $past(s_lvl[2]));
  // R4: no forwarded write without select
  a_r4_sel_needed: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> !$past(sel_n));
  // R7: control A bit 7 is never writable
  a_r7_a_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && core_addr == 4'hA) |-> !core_wmask[7]);
  // R8: flag register write only in the special oscillator setting
  a_r8_c_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && core_addr == 4'hC) |-> $past(osc_field) == OSC_C_WRITABLE);
  // R9: validity register is never written
  a_r9_d_never: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> core_addr != 4'hD);
  // R10: acknowledge is a single cycle and follows a flag register access
  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack |=> !evt_ack);
  a_r10_ack_addr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack |-> core_addr == 4'hC);
  // R12: no time write under the power-fail lock
  a_r12_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && core_addr <= 4'h9) |-> !$past(pwr_lock));
endmodule

// File: tb/mbus_regif_tb.sv
`timescale 1ns/1ps
module mbus_regif_tb_top;
  localparam int unsigned HOLD = 64;

  typedef struct {
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] m;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_mode = 1'b1, addr_stb = 1'b0, data_stb = 1'b0, dir_wr = 1'b1;
  logic sel_n = 1'b1, ext_sel = 1'b0, wipe_n = 1'b1, pwr_lock = 1'b0;
  logic [7:0] bus_in = '0;
  logic [2:0] osc_field = 3'b010;
  logic [7:0] bus_out, core_wdata, core_wmask, core_rdata;
  logic       bus_oe, core_wr, evt_ack;
  logic [3:0] core_addr;
  logic [7:0] core_regs [16];
  logic [7:0] d_val = 8'h00;

  int n_chk = 0, n_fail = 0, ack_cnt = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  mbus_regif #(.SYNC_STAGES(2), .WIPE_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_mode(strobe_mode), .addr_stb(addr_stb),
    .data_stb(data_stb), .dir_wr(dir_wr), .sel_n(sel_n), .ext_sel(ext_sel),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .wipe_n(wipe_n),
    .pwr_lock(pwr_lock), .osc_field(osc_field), .core_addr(core_addr),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_wmask(core_wmask),
    .core_rdata(core_rdata), .evt_ack(evt_ack)
  );

  // simple model of the counting core's register file
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_regs[i] <= 8'h00;
    end else if (core_wr) begin
      core_regs[core_addr] <= (core_regs[core_addr] & ~core_wmask) | (core_wdata & core_wmask);
    end
  end
  assign core_rdata = (core_addr == 4'hD) ? d_val : core_regs[core_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && core_wr) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R8/R9/R12", "unexpected core write", {core_addr, core_wdata, 4'h0}, 16'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(core_addr == e.a && core_wdata == e.d && core_wmask == e.m, e.req, "core write",
            {core_addr, core_wdata, core_wmask[7:4]}, {e.a, e.d, e.m[7:4]});
      end
    end
    if (rst_n && evt_ack) ack_cnt++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_core(input logic [3:0] a, input logic [7:0] d, input logic [7:0] m,
                             input string req);
    exp_t e;
    e.a = a; e.d = d; e.m = m; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic addr_phase(input logic [7:0] a, input logic x);
    bus_in = a; ext_sel = x; addr_stb = 1'b1;
    wait_n(6);
    addr_stb = 1'b0;
    wait_n(6);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic x,
                          input logic sn);
    addr_phase(a, x);
    sel_n = sn; bus_in = d;
    if (strobe_mode) begin
      dir_wr = 1'b0; data_stb = 1'b1; wait_n(6);
      data_stb = 1'b0; wait_n(6);
      dir_wr = 1'b1;
    end else begin
      dir_wr = 1'b0; wait_n(6);
      dir_wr = 1'b1; wait_n(6);
    end
    sel_n = 1'b1;
    wait_n(3);
  endtask

  task automatic do_read(input logic [7:0] a, input logic x, input logic sn,
                         output logic [7:0] d, output logic oe, output logic oe_after);
    addr_phase(a, x);
    sel_n = sn;
    data_stb = strobe_mode ? 1'b1 : 1'b0;
    wait_n(6);
    d = bus_out; oe = bus_oe;
    data_stb = strobe_mode ? 1'b0 : 1'b1;
    wait_n(6);
    oe_after = bus_oe;
    sel_n = 1'b1;
    wait_n(3);
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    logic oe, oe2;
    do_read(a, 1'b0, 1'b0, d, oe, oe2);
    chk(oe && d == exp, req, "read data", {7'd0, oe, d}, {8'h01, exp});
    chk(!oe2, req, "bus released after read", {15'd0, oe2}, 16'h0);
  endtask

  initial begin
    logic [7:0] d;
    logic oe, oe2;
    int a0;
    wait_n(4);
    // R13: reset state
    chk(!bus_oe && !core_wr && !evt_ack, "R13", "outputs in reset",
        {13'd0, bus_oe, core_wr, evt_ack}, 16'h0);
    rst_n = 1'b1; wait_n(4);

    // R2 R6: storage write, then R13: bus ignored during reset
    do_write(8'h20, 8'h11, 1'b0, 1'b0);
    rst_n = 1'b0; wait_n(2);
    do_write(8'h20, 8'h99, 1'b0, 1'b0);
    chk(!bus_oe, "R13", "no drive in reset", {15'd0, bus_oe}, 16'h0);
    rst_n = 1'b1; wait_n(4);
    read_chk(8'h20, 8'h11, "R13");

    // R1 R2 R6: storage boundaries
    do_write(8'h0E, 8'hA5, 1'b0, 1'b0);
    do_write(8'hFF, 8'h3C, 1'b0, 1'b0);
    do_write(8'h80, 8'h77, 1'b0, 1'b0);
    read_chk(8'h0E, 8'hA5, "R6");
    read_chk(8'hFF, 8'h3C, "R6");
    read_chk(8'h80, 8'h77, "R1");

    // R6: forwarded time byte; no ack on non-flag read (R10)
    expect_core(4'h4, 8'h12, 8'hFF, "R6");
    do_write(8'h04, 8'h12, 1'b0, 1'b0);
    a0 = ack_cnt;
    read_chk(8'h04, 8'h12, "R6");
    chk(ack_cnt == a0, "R10", "no ack after other read", 16'(ack_cnt - a0), 16'd0);

    // R7: control A bit 7 masked
    expect_core(4'hA, 8'hFF, 8'h7F, "R7");
    do_write(8'h0A, 8'hFF, 1'b0, 1'b0);
    read_chk(8'h0A, 8'h7F, "R7");

    // R8: flag register write gated by oscillator field; R10 ack
    do_write(8'h0C, 8'h55, 1'b0, 1'b0);
    a0 = ack_cnt;
    read_chk(8'h0C, 8'h00, "R8");
    chk(ack_cnt == a0 + 1, "R10", "one ack after flag read", 16'(ack_cnt - a0), 16'd1);
    osc_field = 3'b011;
    expect_core(4'hC, 8'h0F, 8'hFF, "R8");
    do_write(8'h0C, 8'h0F, 1'b0, 1'b0);
    osc_field = 3'b010;

    // R9: validity register
    do_write(8'h0D, 8'hFF, 1'b0, 1'b0);
    d_val = 8'hFF;
    read_chk(8'h0D, 8'h80, "R9");
    d_val = 8'h7F;
    read_chk(8'h0D, 8'h00, "R9");

    // R4: deselected accesses
    do_write(8'h30, 8'h22, 1'b0, 1'b0);
    do_write(8'h30, 8'h44, 1'b0, 1'b1);
    read_chk(8'h30, 8'h22, "R4");
    do_read(8'h30, 1'b0, 1'b1, d, oe, oe2);
    chk(!oe, "R4", "no drive when deselected", {15'd0, oe}, 16'h0);

    // R5: extended select
    do_write(8'h30, 8'h66, 1'b1, 1'b0);
    do_write(8'h05, 8'h66, 1'b1, 1'b0);
    do_read(8'h30, 1'b1, 1'b0, d, oe, oe2);
    chk(!oe, "R5", "no drive with ext select", {15'd0, oe}, 16'h0);
    read_chk(8'h30, 8'h22, "R5");

    // R12: power-fail lock
    pwr_lock = 1'b1;
    do_write(8'h05, 8'h99, 1'b0, 1'b0);
    do_write(8'h30, 8'h88, 1'b0, 1'b0);
    expect_core(4'hB, 8'h5A, 8'hFF, "R12");
    do_write(8'h0B, 8'h5A, 1'b0, 1'b0);
    pwr_lock = 1'b0;
    read_chk(8'h30, 8'h22, "R12");
    read_chk(8'h05, 8'h00, "R12");
    read_chk(8'h0B, 8'h5A, "R12");

    // R3: split-strobe mode
    data_stb = 1'b1; wait_n(6);
    strobe_mode = 1'b0; wait_n(6);
    do_write(8'h40, 8'hC3, 1'b0, 1'b0);
    read_chk(8'h40, 8'hC3, "R3");
    expect_core(4'h6, 8'h21, 8'hFF, "R3");
    do_write(8'h06, 8'h21, 1'b0, 1'b0);
    read_chk(8'h06, 8'h21, "R3");
    do_read(8'h40, 1'b0, 1'b1, d, oe, oe2);
    chk(!oe, "R3", "split mode deselected read", {15'd0, oe}, 16'h0);
    a0 = ack_cnt;
    read_chk(8'h0C, 8'h0F, "R10");
    chk(ack_cnt == a0 + 1, "R10", "ack in split mode", 16'(ack_cnt - a0), 16'd1);

    // R11: short wipe pulse ignored, long one clears storage only
    wipe_n = 1'b0; wait_n(HOLD - 20); wipe_n = 1'b1; wait_n(8);
    read_chk(8'h40, 8'hC3, "R11");
    wipe_n = 1'b0; wait_n(HOLD + 20); wipe_n = 1'b1; wait_n(8);
    read_chk(8'h0E, 8'hFF, "R11");
    read_chk(8'h40, 8'hFF, "R11");
    read_chk(8'hFF, 8'hFF, "R11");
    read_chk(8'h04, 8'h12, "R11");

    wait_n(4);
    chk(exp_q.size() == 0, "R6", "all expected core writes seen", 16'(exp_q.size()), 16'd0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule